// File: doc/BRIEF.md
# Key Scan Chain with Scrambled Order and Leak Monitor

This block holds the five most significant bits of a cipher key in a short design-for-test scan chain. In functional mode, a load strobe copies the key slice into the chain registers in parallel. When scan is enabled, the registers become a serial shift path from `scan_in_i` to `scan_out_o`, with one bit moved per clock.

The order in which key bits sit along the chain is a compile-time choice. The chain can use the natural bit order, or a fixed permutation that hides which scanned-out position belongs to which key bit. A second compile-time option replaces the chain contents with a constant mirror pattern on the first cycle of scan mode, so the real key never leaves through the chain.

A monitor watches the serial output. It keeps the last five bits shifted out. Once a full window has been shifted since scan mode began, it compares that window with the key slice arranged in chain order. On a match it raises a sticky `insecure_o` flag that only reset clears.

Top module: `keyscan_guard`

## Requirements
- R1: After reset, every chain slot holds 0, `scan_out_o` is 0 and `insecure_o` is 0.
- R2: Slice bit i is `key_top_i[i]`, which is key bit 123+i. When `scan_en_i` is low and `load_i` is high, chain slot j takes slice bit perm(j) at the clock edge. Without scrambling, perm is the identity, so the scanned-out stream, first bit first, equals `key_top_i[4:0]` read from MSB down.
- R3: When `scan_en_i` and `load_i` are both low, the chain holds its contents and changes on `key_top_i` have no effect.
- R4: A shift cycle is a cycle in scan mode that is not a mirror-entry cycle. In a shift cycle, `scan_out_o` shows slot 4, slot 0 takes `scan_in_i`, and slot j takes slot j-1. A bit entering at `scan_in_i` therefore leaves at `scan_out_o` five shift cycles later. Outside shift cycles, `scan_out_o` is 0.
- R5: With scrambling and the default permutation, slots 4..0 hold slice bits 1, 3, 0, 4, 2. The scanned-out stream, first bit first, is therefore s1, s3, s0, s4, s2.
- R6: While `scan_en_i` is high, `load_i` and `key_top_i` do not change the chain contents.
- R7: With the mirror option, the first cycle with `scan_en_i` high after a cycle with it low is a mirror-entry cycle. In that cycle no shift happens, `scan_out_o` is 0, and slot j takes bit j of the mirror pattern. Shifting starts on the next cycle, so the stream is the mirror pattern MSB first.
- R8: The monitor records `scan_out_o` on shift cycles only. `insecure_o` rises at the end of a scan-mode cycle in which the last five recorded bits, oldest first, equal chain slots 4..0 of the arranged key slice, provided at least five shift cycles have occurred since scan mode was entered.
- R9: No flag is raised while `scan_en_i` is low, or in a scan-mode cycle that follows fewer than five shift cycles since entry. This holds even if the recorded window already matches.
- R10: Once set, `insecure_o` stays 1 through loads, scanning and idle cycles until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_top_i | input | 5 | Top key slice; bit i is key bit 123+i |
| load_i | input | 1 | Parallel load strobe, used only when scan is off |
| scan_en_i | input | 1 | Selects serial scan mode |
| scan_in_i | input | 1 | Serial data into chain slot 0 |
| scan_out_o | output | 1 | Serial data from chain slot 4 during shift cycles |
| insecure_o | output | 1 | Sticky flag set when the key slice is seen on the scan output |

## Verification
The bench builds three copies that share one set of inputs:
- the default scrambled permutation without the mirror option,
- the identity order,
- the scrambled order with mirror pattern 01101.

Applying one key slice to all three shows the plain and permuted streams side by side. It also shows the one-cycle delay that the mirror-entry cycle adds, and a mirrored chain that never raises the flag while the other two do. The identity copy makes the scan-in to scan-out path and the window qualification easy to predict, because its reference equals the key slice.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_SHIFT  = 2'd2,
    OP_MIRROR = 2'd3
  } chain_op_e;

  // Priority: scan mode wins over the parallel strobe; the mirror overwrite
  // takes the first scan cycle only when the option is built in.
  function automatic chain_op_e pick_op(input logic scan_en,
                                        input logic entry,
                                        input logic load,
                                        input logic mirror_en);
    if (scan_en) begin
      if (entry && mirror_en) return OP_MIRROR;
      return OP_SHIFT;
    end
    if (load) return OP_LOAD;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/keyscan_chain.sv
module keyscan_chain
  import keyscan_pkg::*;
#(
  parameter int unsigned          CHAIN_LEN  = 5,
  parameter bit                   MIRROR_EN  = 1'b0,
  parameter logic [CHAIN_LEN-1:0] MIRROR_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en_i,
  input  logic                 load_i,
  input  logic                 scan_in_i,
  input  logic [CHAIN_LEN-1:0] load_word_i,
  output logic [CHAIN_LEN-1:0] chain_q,
  output logic                 entry_evt,
  output logic                 shift_evt,
  output logic                 scan_out_o
);

  logic      scan_en_q;
  chain_op_e op;

  assign entry_evt  = scan_en_i && !scan_en_q;
  assign op         = pick_op(scan_en_i, entry_evt, load_i, MIRROR_EN);
  assign shift_evt  = (op == OP_SHIFT);
  assign scan_out_o = shift_evt & chain_q[CHAIN_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_en_q <= 1'b0;
    else        scan_en_q <= scan_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      case (op)
        OP_LOAD:   chain_q <= load_word_i;
        OP_SHIFT:  chain_q <= {chain_q[CHAIN_LEN-2:0], scan_in_i};
        OP_MIRROR: chain_q <= MIRROR_VAL;
        default:   chain_q <= chain_q;
      endcase
    end
  end

endmodule

// File: rtl/keyscan_monitor.sv
module keyscan_monitor #(
  parameter int unsigned CHAIN_LEN = 5,
  localparam int unsigned CNT_W    = $clog2(CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en_i,
  input  logic                 shift_evt,
  input  logic                 scan_bit_i,
  input  logic [CHAIN_LEN-1:0] ref_word_i,
  output logic                 window_full,
  output logic                 leak_hit,
  output logic                 insecure_o
);

  logic [CNT_W-1:0]     cnt_q;
  logic [CHAIN_LEN-1:0] win_q;
  logic                 flag_q;

  assign window_full = (cnt_q == CNT_W'(CHAIN_LEN));
  // bitwise XNOR reduction: every window bit agrees with the reference
  assign leak_hit    = scan_en_i && window_full && (&(win_q ~^ ref_word_i));
  assign insecure_o  = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!scan_en_i) begin
      cnt_q <= '0;
    end else if (shift_evt && !window_full) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_q <= '0;
    else if (shift_evt) win_q <= {win_q[CHAIN_LEN-2:0], scan_bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_q | leak_hit;
  end

endmodule

// File: rtl/keyscan_guard.sv
module keyscan_guard #(
  parameter int unsigned                CHAIN_LEN  = 5,
  parameter int unsigned                IDX_W      = 3,
  parameter bit                         SCRAMBLE   = 1'b1,
  // slot j reads slice bit PERM[j*IDX_W +: IDX_W]; slot 4 sits in the MSBs
  parameter logic [CHAIN_LEN*IDX_W-1:0] PERM       = {3'd1, 3'd3, 3'd0, 3'd4, 3'd2},
  parameter bit                         MIRROR_EN  = 1'b0,
  parameter logic [CHAIN_LEN-1:0]       MIRROR_VAL = 5'b01101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHAIN_LEN-1:0] key_top_i,
  input  logic                 load_i,
  input  logic                 scan_en_i,
  input  logic                 scan_in_i,
  output logic                 scan_out_o,
  output logic                 insecure_o
);

  // Places slice bits into chain slots, in the same order for load and compare.
  function automatic logic [CHAIN_LEN-1:0] arrange(input logic [CHAIN_LEN-1:0] slice);
    logic [CHAIN_LEN-1:0] res;
    logic [IDX_W-1:0]     idx;
    res = '0;
    for (int j = 0; j < CHAIN_LEN; j++) begin
      idx = SCRAMBLE ? PERM[j*IDX_W +: IDX_W] : IDX_W'(j);
      if (int'(idx) < CHAIN_LEN) res[j] = slice[idx];
      else                       res[j] = slice[j];
    end
    return res;
  endfunction

  logic [CHAIN_LEN-1:0] ref_word;
  logic [CHAIN_LEN-1:0] chain_q;
  logic                 entry_evt;
  logic                 shift_evt;
  logic                 window_full;
  logic                 leak_hit;

  assign ref_word = arrange(key_top_i);

  keyscan_chain #(
    .CHAIN_LEN (CHAIN_LEN),
    .MIRROR_EN (MIRROR_EN),
    .MIRROR_VAL(MIRROR_VAL)
  ) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en_i  (scan_en_i),
    .load_i     (load_i),
    .scan_in_i  (scan_in_i),
    .load_word_i(ref_word),
    .chain_q    (chain_q),
    .entry_evt  (entry_evt),
    .shift_evt  (shift_evt),
    .scan_out_o (scan_out_o)
  );

  keyscan_monitor #(
    .CHAIN_LEN(CHAIN_LEN)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en_i  (scan_en_i),
    .shift_evt  (shift_evt),
    .scan_bit_i (scan_out_o),
    .ref_word_i (ref_word),
    .window_full(window_full),
    .leak_hit   (leak_hit),
    .insecure_o (insecure_o)
  );

endmodule

// File: rtl/keyscan_guard_chk.sv
module keyscan_guard_chk #(
  parameter int unsigned          CHAIN_LEN  = 5,
  parameter bit                   MIRROR_EN  = 1'b0,
  parameter logic [CHAIN_LEN-1:0] MIRROR_VAL = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_i,
  input logic                 scan_en_i,
  input logic                 scan_in_i,
  input logic                 scan_out_o,
  input logic                 insecure_o,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic                 entry_evt,
  input logic                 shift_evt,
  input logic [CHAIN_LEN-1:0] ref_word
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !scan_en_i) |=> (chain_q == $past(ref_word)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !scan_en_i) |=> $stable(chain_q));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_i |-> !scan_out_o);

  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (chain_q[0] == $past(scan_in_i)));

  p_scan_blocks_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_i && !(entry_evt && MIRROR_EN))
      |=> (chain_q == {$past(chain_q[CHAIN_LEN-2:0]), $past(scan_in_i)}));

  generate
    if (MIRROR_EN) begin : g_mirror
      p_mirror_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_evt |=> (chain_q == MIRROR_VAL));
      p_mirror_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_evt |-> !scan_out_o);
    end
  endgenerate

  p_flag_in_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(insecure_o) |-> $past(scan_en_i));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    insecure_o |=> insecure_o);

endmodule

bind keyscan_guard keyscan_guard_chk #(
  .CHAIN_LEN (CHAIN_LEN),
  .MIRROR_EN (MIRROR_EN),
  .MIRROR_VAL(MIRROR_VAL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .scan_en_i (scan_en_i),
  .scan_in_i (scan_in_i),
  .scan_out_o(scan_out_o),
  .insecure_o(insecure_o),
  .chain_q   (chain_q),
  .entry_evt (entry_evt),
  .shift_evt (shift_evt),
  .ref_word  (ref_word)
);

// File: tb/keyscan_guard_tb.sv
module keyscan_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MIRR = 5'b01101;
  // {key slice s4..s0, scrambled stream first-out-first}; plain stream = slice
  localparam logic [9:0] VEC [6] = '{
    {5'b10000, 5'b00010},
    {5'b00001, 5'b00100},
    {5'b10110, 5'b10011},
    {5'b01011, 5'b11100},
    {5'b11111, 5'b11111},
    {5'b00000, 5'b00000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] key_top = '0;
  logic load = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
  logic so_d, so_p, so_m, fl_d, fl_p, fl_m;
  int total = 0, fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyscan_guard u_dut (
    .clk(clk), .rst_n(rst_n), .key_top_i(key_top), .load_i(load),
    .scan_en_i(scan_en), .scan_in_i(scan_in), .scan_out_o(so_d), .insecure_o(fl_d));

  keyscan_guard #(.SCRAMBLE(1'b0)) u_plain (
    .clk(clk), .rst_n(rst_n), .key_top_i(key_top), .load_i(load),
    .scan_en_i(scan_en), .scan_in_i(scan_in), .scan_out_o(so_p), .insecure_o(fl_p));

  keyscan_guard #(.MIRROR_EN(1'b1), .MIRROR_VAL(MIRR)) u_mirr (
    .clk(clk), .rst_n(rst_n), .key_top_i(key_top), .load_i(load),
    .scan_en_i(scan_en), .scan_in_i(scan_in), .scan_out_o(so_m), .insecure_o(fl_m));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_load(input logic [4:0] slice);
    key_top = slice; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // five shift cycles on the non-mirror copies, stream first-out in MSB
  task automatic scan5(output logic [4:0] st_d, output logic [4:0] st_p);
    for (int c = 0; c < 5; c++) begin
      scan_en = 1'b1; scan_in = 1'b0;
      #1;
      st_d[4-c] = so_d; st_p[4-c] = so_p;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [4:0] st_d, st_p, st_m, sl, ex;
    do_reset();
    #1;
    check("R1 scan_out", {5'b0, so_d, so_p, so_m}, 8'h0);
    check("R1 insecure", {5'b0, fl_d, fl_p, fl_m}, 8'h0);

    // table walk: load, idle with disturbed key, then scan 7 cycles
    for (int i = 0; i < 6; i++) begin
      sl = VEC[i][9:5]; ex = VEC[i][4:0];
      do_reset();
      #1;
      check("R1 flags after reset", {5'b0, fl_d, fl_p, fl_m}, 8'h0);
      do_load(sl);
      key_top = ~sl;                 // R3: no strobe, key change ignored
      @(negedge clk);
      key_top = sl;
      st_m = '0;
      for (int c = 0; c < 7; c++) begin
        scan_en = 1'b1; scan_in = 1'b0;
        #1;
        if (c < 5) begin st_d[4-c] = so_d; st_p[4-c] = so_p; end
        if (c == 0) check("R7 entry cycle quiet", {7'b0, so_m}, 8'h0);
        if (c >= 1 && c <= 5) st_m[5-c] = so_m;
        if (c == 5) check("R9 no flag before window", {6'b0, fl_d, fl_p}, 8'h0);
        if (c == 6) check("R8 flag one edge after window", {6'b0, fl_d, fl_p}, 8'h3);
        @(negedge clk);
      end
      scan_en = 1'b0;
      #1;
      check("R2/R3 plain stream", {3'b0, st_p}, {3'b0, sl});
      check("R5 scrambled stream", {3'b0, st_d}, {3'b0, ex});
      check("R7 mirror stream", {3'b0, st_m}, {3'b0, MIRR});
      check("R8 mirror never flags", {7'b0, fl_m}, 8'h0);
      check("R4 idle output quiet", {5'b0, so_d, so_p, so_m}, 8'h0);
    end

    // R6: load strobe and new key during scan do not disturb the chain
    do_reset();
    do_load(5'b10110);
    key_top = 5'b01001; load = 1'b1;
    scan5(st_d, st_p);
    load = 1'b0; scan_en = 1'b0;
    check("R6 plain ignores load", {3'b0, st_p}, 8'h16);
    check("R6 scrambled ignores load", {3'b0, st_d}, 8'h13);

    // R4: bits entered on scan_in leave five shift cycles later
    do_reset();
    key_top = 5'b00000;
    for (int c = 0; c < 10; c++) begin
      scan_en = 1'b1;
      scan_in = (c < 5) ? 1'(5'b11001 >> (4 - c)) : 1'b0;
      #1;
      if (c < 5) st_d[4-c] = so_p; else st_p[9-c] = so_p;
      @(negedge clk);
    end
    scan_en = 1'b0;
    check("R4 zeros from reset chain", {3'b0, st_d}, 8'h00);
    check("R4 scan_in pass-through", {3'b0, st_p}, 8'h19);

    // R9: full matching window but scan dropped, then short re-entry
    do_reset();
    do_load(5'b10110);
    scan5(st_d, st_p);
    scan_en = 1'b0;
    #1;
    check("R9 window matched, scan off", {6'b0, fl_d, fl_p}, 8'h0);
    @(negedge clk);
    scan_en = 1'b1;
    @(negedge clk);
    scan_en = 1'b0;
    #1;
    check("R9 re-entry below five shifts", {6'b0, fl_d, fl_p}, 8'h0);

    // R10: sticky flag through loads and idle, cleared by reset
    @(negedge clk);
    do_load(5'b01011);
    scan5(st_d, st_p);
    scan_en = 1'b1;
    @(negedge clk);
    scan_en = 1'b0;
    #1;
    check("R8 plain flag set", {7'b0, fl_p}, 8'h1);
    do_load(5'b00111);
    repeat (3) @(negedge clk);
    #1;
    check("R10 flag sticky", {7'b0, fl_p}, 8'h1);
    do_reset();
    #1;
    check("R1/R10 reset clears flag", {7'b0, fl_p}, 8'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule